// File: doc/BRIEF.md
# Instruction Length and Cycle Cost Meter

This block sits beside a program-word stream for a compact two-operand machine with three instruction layouts: double-operand, single-operand and relative jump. Each accepted 16-bit word is classed as either the first word of an instruction or one of its trailing extension words. The block decodes the first word's layout and operand-mode fields and works out how many words the instruction occupies and how many clock cycles it costs. It then swallows the extension words that follow without decoding them.

When the last word of an instruction has been accepted, the block raises a one-cycle result strobe. The strobe carries the layout, the length and the cycle cost. Two saturating running totals, one of words and one of cycles, grow on the same edge. A synchronous clear input resets both totals. Operand values, memory traffic and execution are not modelled.

Top module: `insn_cost_meter`

## Requirements
- R1: Layout decode of a first word `w`:
  - any value in `w[15:14]` other than 00 gives double-operand (fmt 0);
  - `w[15:13]` = 001 gives jump (fmt 2);
  - `w[15:10]` = 000100 gives single-operand (fmt 1);
  - any other word is illegal (fmt 3).
- R2: Length is 1 word, plus 1 when the source mode is 01, plus 1 when the source mode is 11 and the source register is 0.
  - Double-operand words also add 1 when Ad = 1.
  - In double-operand words the fields are: source register `w[11:8]`, Ad `w[7]`, source mode `w[5:4]`, destination register `w[3:0]`.
  - In single-operand words the mode is `w[5:4]` and the register is `w[3:0]`.
- R3: A double-operand instruction costs 1 cycle, plus the source-mode cost, plus 3 when Ad = 1, plus 1 when Ad = 0 and the destination register is 0.
  - The source-mode cost is 0 for mode 00, 2 for mode 01, and 1 for modes 10 and 11.
- R4: A single-operand instruction costs 1 cycle plus the source-mode cost of its mode field.
- R5: A jump is 1 word and 2 cycles. An illegal word is 1 word and 1 cycle.
- R6: After a first word of length L, the next L-1 words accepted with `in_valid` high are taken as extension words and are never decoded. Cycles with `in_valid` low change nothing.
- R7: `res_valid` is high for exactly the cycle after the edge that accepts an instruction's final word, and stays low after every non-final word.
- R8: The totals add the instruction's length and cycles on the same edge that raises `res_valid`.
- R9: Each total saturates at its all-ones value and never wraps.
- R10: `tot_clr` zeroes both totals on the next edge. It takes priority over an instruction completing on that edge, which still strobes its result.
- R11: After reset, `res_valid` is low, both totals are zero, and the next valid word is treated as a first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word present on `in_word` this cycle |
| in_word | input | 16 | Program word |
| tot_clr | input | 1 | Synchronous clear of both totals |
| res_valid | output | 1 | One-cycle result strobe |
| res_fmt | output | 2 | Layout: 0 double, 1 single, 2 jump, 3 illegal |
| res_len | output | 2 | Instruction length in words |
| res_cycles | output | 3 | Instruction cycle cost |
| total_words | output | CNT_W | Saturating word total |
| total_cycles | output | CNT_W | Saturating cycle total |

## Verification
The result strobe, its fields and both totals come from registers. All of them are due one clock edge after the final word of an instruction is presented, and `tot_clr` acts on that same single edge. The bench drives each word at a falling edge and reads the outputs at the next falling edge, exactly half a cycle after the capturing edge. In those reads it requires the strobe to be low after every extension word and every idle cycle, and high, with the expected fields and totals, after the final word.

// File: rtl/icm_pkg.sv
package icm_pkg;

  typedef enum logic [1:0] {
    FMT_DUAL   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_JUMP   = 2'd2,
    FMT_BAD    = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic [1:0] len;
    logic [2:0] cyc;
  } cost_t;

  function automatic fmt_e fmt_of(input logic [15:0] w);
    if (w[15:14] != 2'b00)       return FMT_DUAL;
    if (w[15:13] == 3'b001)      return FMT_JUMP;
    if (w[15:10] == 6'b000100)   return FMT_SINGLE;
    return FMT_BAD;
  endfunction

  // source operand needs an extension word (indexed or immediate)
  function automatic logic src_has_ext(input logic [1:0] md, input logic [3:0] rg);
    return (md == 2'b01) || (md == 2'b11 && rg == 4'd0);
  endfunction

  function automatic logic [2:0] src_cost(input logic [1:0] md);
    case (md)
      2'b00:   return 3'd0;
      2'b01:   return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  function automatic cost_t cost_of(input logic [15:0] w);
    cost_t c;
    c.fmt = fmt_of(w);
    c.len = 2'd1;
    c.cyc = 3'd1;
    case (c.fmt)
      FMT_DUAL: begin
        c.len = 2'd1 + {1'b0, src_has_ext(w[5:4], w[11:8])} + {1'b0, w[7]};
        c.cyc = 3'd1 + src_cost(w[5:4]) + (w[7] ? 3'd3 : 3'd0)
              + {2'b00, (!w[7] && w[3:0] == 4'd0)};
      end
      FMT_SINGLE: begin
        c.len = 2'd1 + {1'b0, src_has_ext(w[5:4], w[3:0])};
        c.cyc = 3'd1 + src_cost(w[5:4]);
      end
      FMT_JUMP: c.cyc = 3'd2;
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/icm_decode.sv
module icm_decode
  import icm_pkg::*;
(
  input  logic [15:0] word,
  output cost_t       cost
);
  always_comb cost = cost_of(word);
endmodule

// File: rtl/icm_track.sv
module icm_track
  import icm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  cost_t dec,
  output logic  done,
  output cost_t fin,
  output logic  res_valid,
  output cost_t res_cost
);
  logic [1:0] left_q;
  cost_t      hold_q;

  logic accept_op, accept_ext;
  assign accept_op  = in_valid && (left_q == 2'd0);
  assign accept_ext = in_valid && (left_q != 2'd0);
  assign done       = (accept_op && dec.len == 2'd1) || (accept_ext && left_q == 2'd1);
  assign fin        = accept_op ? dec : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q    <= 2'd0;
      hold_q    <= '0;
      res_valid <= 1'b0;
      res_cost  <= '0;
    end else begin
      if (accept_op) begin
        left_q <= dec.len - 2'd1;
        hold_q <= dec;
      end else if (accept_ext) begin
        left_q <= left_q - 2'd1;
      end
      res_valid <= done;
      if (done) res_cost <= fin;
    end
  end

  a_r6_ext_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && left_q != 2'd0) |=> left_q == $past(left_q) - 2'd1);

  a_r7_no_strobe_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && left_q == 2'd2) |=> !res_valid);

  a_r5_jump_cost: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_cost.fmt == FMT_JUMP) |-> (res_cost.len == 2'd1 && res_cost.cyc == 3'd2));

  a_r3_cycles_cover_len: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_cost.cyc >= {1'b0, res_cost.len});
endmodule

// File: rtl/icm_totals.sv
module icm_totals #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [1:0]       add_len,
  input  logic [2:0]       add_cyc,
  output logic [CNT_W-1:0] words,
  output logic [CNT_W-1:0] cycles
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W:0] w_sum, c_sum;
  assign w_sum = {1'b0, words}  + {{(CNT_W-1){1'b0}}, add_len};
  assign c_sum = {1'b0, cycles} + {{(CNT_W-2){1'b0}}, add_cyc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words  <= '0;
      cycles <= '0;
    end else if (clr) begin
      words  <= '0;
      cycles <= '0;
    end else if (add_en) begin
      words  <= w_sum[CNT_W] ? TOP : w_sum[CNT_W-1:0];
      cycles <= c_sum[CNT_W] ? TOP : c_sum[CNT_W-1:0];
    end
  end

  a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (words == '0 && cycles == '0));

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (words >= $past(words) && cycles >= $past(cycles)));
endmodule

// File: rtl/insn_cost_meter.sv
module insn_cost_meter
  import icm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [15:0]      in_word,
  input  logic             tot_clr,
  output logic             res_valid,
  output logic [1:0]       res_fmt,
  output logic [1:0]       res_len,
  output logic [2:0]       res_cycles,
  output logic [CNT_W-1:0] total_words,
  output logic [CNT_W-1:0] total_cycles
);
  cost_t dec_cost, fin_cost, res_cost;
  logic  insn_done;

  icm_decode u_dec (.word(in_word), .cost(dec_cost));

  icm_track u_trk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dec(dec_cost),
    .done(insn_done), .fin(fin_cost), .res_valid(res_valid), .res_cost(res_cost)
  );

  icm_totals #(.CNT_W(CNT_W)) u_tot (
    .clk(clk), .rst_n(rst_n), .clr(tot_clr), .add_en(insn_done),
    .add_len(fin_cost.len), .add_cyc(fin_cost.cyc),
    .words(total_words), .cycles(total_cycles)
  );

  assign res_fmt    = res_cost.fmt;
  assign res_len    = res_cost.len;
  assign res_cycles = res_cost.cyc;
endmodule

// File: tb/insn_cost_meter_test.sv
module insn_cost_meter_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, in_valid = 1'b0, tot_clr = 1'b0;
  logic [15:0] in_word = 16'h0;
  logic res_valid;
  logic [1:0] res_fmt, res_len;
  logic [2:0] res_cycles;
  logic [31:0] total_words, total_cycles;

  insn_cost_meter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word), .tot_clr(tot_clr),
    .res_valid(res_valid), .res_fmt(res_fmt), .res_len(res_len), .res_cycles(res_cycles),
    .total_words(total_words), .total_cycles(total_cycles)
  );

  logic s_valid = 1'b0;
  logic [15:0] s_word = 16'h2000;
  logic s_rv;
  logic [1:0] s_fmt, s_len;
  logic [2:0] s_cyc;
  logic [7:0] s_words, s_cycles;

  insn_cost_meter #(.CNT_W(8)) uut_sat (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_word(s_word), .tot_clr(1'b0),
    .res_valid(s_rv), .res_fmt(s_fmt), .res_len(s_len), .res_cycles(s_cyc),
    .total_words(s_words), .total_cycles(s_cycles)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  longint exp_w = 0, exp_c = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bench-side cost model: returns {fmt, len, cyc} as integers
  task automatic model(input logic [15:0] w, output int f, output int l, output int c);
    int md, sr, dr, ad;
    md = int'(w[5:4]); sr = int'(w[11:8]); dr = int'(w[3:0]); ad = int'(w[7]);
    if (w[15:12] >= 4'd4) begin
      f = 0;
      l = 1 + (md == 1 ? 1 : 0) + ((md == 3 && sr == 0) ? 1 : 0) + ad;
      c = 1 + (md == 0 ? 0 : (md == 1 ? 2 : 1)) + 3 * ad + ((ad == 0 && dr == 0) ? 1 : 0);
    end else if (w[15:13] == 3'b001) begin
      f = 2; l = 1; c = 2;
    end else if (w[15:10] == 6'b000100) begin
      f = 1;
      l = 1 + (md == 1 ? 1 : 0) + ((md == 3 && dr == 0) ? 1 : 0);
      c = 1 + (md == 0 ? 0 : (md == 1 ? 2 : 1));
    end else begin
      f = 3; l = 1; c = 1;
    end
  endtask

  task automatic push(input logic [15:0] w, input bit clr);
    in_valid = 1'b1; in_word = w; tot_clr = clr;
    @(negedge clk);
    in_valid = 1'b0; tot_clr = 1'b0;
  endtask

  task automatic run_insn(input logic [15:0] w, input bit gap, input bit clr_at_end);
    int f, l, c;
    model(w, f, l, c);
    for (int k = 0; k < l; k++) begin
      // extension words look like opcode words to prove they are swallowed
      push((k == 0) ? w : 16'h4A85 ^ 16'(k), (k == l - 1) ? clr_at_end : 1'b0);
      if (k < l - 1) chk(res_valid == 1'b0, "R6/R7 strobe low after non-final word", res_valid, 0);
    end
    if (clr_at_end) begin exp_w = 0; exp_c = 0; end
    else begin exp_w += l; exp_c += c; end
    chk(res_valid == 1'b1, "R7 strobe after final word", res_valid, 1);
    chk(res_fmt == 2'(f), "R1 layout", res_fmt, f);
    chk(res_len == 2'(l), "R2 length", res_len, l);
    chk(res_cycles == 3'(c), (f == 1) ? "R4 cycles" : (f == 0 ? "R3 cycles" : "R5 cycles"), res_cycles, c);
    chk(total_words == 32'(exp_w), clr_at_end ? "R10 clear words" : "R8 word total", total_words, exp_w);
    chk(total_cycles == 32'(exp_c), clr_at_end ? "R10 clear cycles" : "R8 cycle total", total_cycles, exp_c);
    if (gap) begin
      in_word = 16'h4FFF;
      @(negedge clk);
      chk(res_valid == 1'b0, "R6 idle cycle no strobe", res_valid, 0);
      chk(total_words == 32'(exp_w), "R6 idle cycle totals", total_words, exp_w);
    end
  endtask

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R11 reset strobe", res_valid, 0);
    chk(total_words == 0, "R11 reset words", total_words, 0);
    chk(total_cycles == 0, "R11 reset cycles", total_cycles, 0);

    // double-operand sweep over modes, Ad and register corners
    for (int md = 0; md < 4; md++)
      for (int ad = 0; ad < 2; ad++)
        for (int s = 0; s < 2; s++)
          for (int d = 0; d < 2; d++) begin
            w = {4'(4 + md * 3 + ad), (s == 0) ? 4'd0 : 4'd5, 1'(ad), 1'(d), 2'(md), (d == 0) ? 4'd0 : 4'd7};
            run_insn(w, (md + d) % 2 == 1, 1'b0);
          end
    // single-operand sweep
    for (int md = 0; md < 4; md++)
      for (int r = 0; r < 2; r++) begin
        w = {6'b000100, 3'(md + r), 1'b0, 2'(md), (r == 0) ? 4'd0 : 4'd3};
        run_insn(w, r == 1, 1'b0);
      end
    // jumps and illegal words
    run_insn(16'h2000, 1'b0, 1'b0);
    run_insn(16'h3FFF, 1'b1, 1'b0);
    run_insn(16'h2C05, 1'b0, 1'b0);
    run_insn(16'h0000, 1'b0, 1'b0);
    run_insn(16'h1400, 1'b1, 1'b0);
    run_insn(16'h1FFF, 1'b0, 1'b0);
    run_insn(16'h0FFF, 1'b0, 1'b0);
    // R10: clear coinciding with a completing 3-word instruction, then restart
    run_insn(16'h5090 | 16'h0002, 1'b0, 1'b0);
    run_insn(16'h4F91, 1'b0, 1'b1);
    run_insn(16'h4510, 1'b0, 1'b0);
    // R10: clear while idle
    tot_clr = 1'b1; @(negedge clk); tot_clr = 1'b0;
    exp_w = 0; exp_c = 0;
    chk(total_words == 0 && total_cycles == 0, "R10 idle clear", total_words + total_cycles, 0);
    run_insn(16'h2000, 1'b0, 1'b0);

    // R9: saturation on an 8-bit instance (each jump: 1 word, 2 cycles)
    repeat (130) begin s_valid = 1'b1; @(negedge clk); end
    s_valid = 1'b0; @(negedge clk);
    chk(s_words == 8'd130, "R9 words below limit", s_words, 130);
    chk(s_cycles == 8'd255, "R9 cycles saturate", s_cycles, 255);
    repeat (130) begin s_valid = 1'b1; @(negedge clk); end
    s_valid = 1'b0; @(negedge clk);
    chk(s_words == 8'd255, "R9 words saturate", s_words, 255);
    chk(s_cycles == 8'd255, "R9 cycles hold", s_cycles, 255);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule